// File: doc/BRIEF.md
# Free-running 40-bit timestamp counter

This block keeps a 40-bit timestamp that climbs by one on each cycle where an external tick enable is high, once software has turned counting on. It is meant for a slow time base, nominally near 983 kHz. The count never reloads and raises no interrupt. When it passes its largest value it rolls over to zero and carries on, with no flag. Software reads the count over a simple register bus. One word gives the lower 32 bits. A second word gives the top 8 bits in its low byte, the run control in bit 8 and zeros above that.

A 40-bit value does not fit in one 32-bit read, so a carry can fall between the two reads. To keep the halves consistent, a read of the low word copies the top byte into a shadow. The next read of the high word returns that copy and then drops it. A read of the high word with no pending copy returns the live top byte. Tick generation and bus adaptation are done outside the block.

Top module: `timestamp_counter`

## Requirements
- R1: After reset the count equals the parameter INIT_COUNT (default 0), counting is off and no shadow byte is pending.
- R2: The count rises by exactly one on each clock edge where counting is on and tickEn is 1. On every other edge it holds.
- R3: Reading address 0x60 returns count bits 31:0.
- R4: Reading address 0x64 returns a top byte in bits 7:0, the run control in bit 8 and zeros in bits 31:9. Any other address reads as zero.
- R5: A write to 0x64 loads bit 8 of the write data into the run control (1 runs, 0 stops). The other bits of the write data have no effect.
- R6: Writes to 0x60 or to any address other than 0x64 change neither the count nor the run control.
- R7: A read strobe at 0x60 captures count bits 39:32. The next read of 0x64 returns that captured byte even if a carry into bit 32 has happened since. That high read then releases the capture.
- R8: A read of 0x64 with no capture pending returns the live count bits 39:32.
- R9: From all ones the count rolls over to zero on the next counting edge and keeps counting.
- R10: Read strobes never change the count or the run control.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Time-base tick, one clock wide |
| regAddr | input | 8 | Register byte address |
| regRd | input | 1 | Read strobe |
| regWe | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |

## Verification
Two situations are hard to reach from the ports: a carry out of bit 31 between a low read and the high read that follows it, and the rollover of the full 40 bits. Starting from zero, either one would need billions of ticks. The bench therefore builds two copies with INIT_COUNT set just below a low-word carry. The copies differ only in the top byte: 0x00 in one and 0xFF in the other. One low read, a few ticks and then a high read produce a stale shadow in one copy and a full rollover in the other. A behavioural model compares every read value on every clock.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  parameter int TSC_CNT_W  = 40;
  parameter int TSC_DATA_W = 32;
  parameter int TSC_ADDR_W = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic countStep;
    logic captureHi;
    logic releaseHi;
  } tscStrobes_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } tscRdSel_t;
endpackage

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
  import tsc_pkg::*;
#(
  parameter int ADDR_W = TSC_ADDR_W,
  parameter logic [ADDR_W-1:0] LO_ADDR = 'h60,
  parameter logic [ADDR_W-1:0] HI_ADDR = 'h64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWe,
  input  logic              wrRunBit,
  output tscStrobes_t       strobes,
  output tscRdSel_t         rdSel,
  output logic              enState
);
  logic hitLo;
  logic hitHi;

  assign hitLo = (regAddr == LO_ADDR);
  assign hitHi = (regAddr == HI_ADDR);

  // run control: only a write to the high word touches it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enState <= 1'b0;
    end else if (regWe && hitHi) begin
      enState <= wrRunBit;
    end
  end

  always_comb begin
    strobes.countStep = enState & tickEn;
    strobes.captureHi = regRd & hitLo;
    strobes.releaseHi = regRd & hitHi;
  end

  always_comb begin
    if (hitLo)      rdSel = SEL_LO;
    else if (hitHi) rdSel = SEL_HI;
    else            rdSel = SEL_NONE;
  end
endmodule

// File: rtl/tsc_datapath.sv
module tsc_datapath
  import tsc_pkg::*;
#(
  parameter int CNT_W  = TSC_CNT_W,
  parameter int DATA_W = TSC_DATA_W,
  parameter int EN_BIT = 8,
  parameter logic [CNT_W-1:0] INIT_COUNT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  tscStrobes_t       strobes,
  input  tscRdSel_t         rdSel,
  input  logic              enState,
  output logic [CNT_W-1:0]  cntVal,
  output logic [DATA_W-1:0] rdData
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [HI_W-1:0]   shadowHi;
  logic              shadowValid;
  logic [HI_W-1:0]   hiField;
  logic [DATA_W-1:0] hiWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= INIT_COUNT;
    end else if (strobes.countStep) begin
      cntVal <= cntVal + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowHi    <= '0;
      shadowValid <= 1'b0;
    end else if (strobes.captureHi) begin
      shadowHi    <= cntVal[CNT_W-1:DATA_W];
      shadowValid <= 1'b1;
    end else if (strobes.releaseHi) begin
      shadowValid <= 1'b0;
    end
  end

  assign hiField = shadowValid ? shadowHi : cntVal[CNT_W-1:DATA_W];

  // high word: top byte at the bottom, run control at EN_BIT
  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_hiWord
      if (b < HI_W) begin : g_byte
        assign hiWord[b] = hiField[b];
      end else if (b == EN_BIT) begin : g_run
        assign hiWord[b] = enState;
      end else begin : g_zero
        assign hiWord[b] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    case (rdSel)
      SEL_LO:  rdData = cntVal[DATA_W-1:0];
      SEL_HI:  rdData = hiWord;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/timestamp_counter.sv
module timestamp_counter
  import tsc_pkg::*;
#(
  parameter int CNT_W  = TSC_CNT_W,
  parameter int DATA_W = TSC_DATA_W,
  parameter int ADDR_W = TSC_ADDR_W,
  parameter int EN_BIT = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 'h60,
  parameter logic [ADDR_W-1:0] HI_ADDR = 'h64,
  parameter logic [CNT_W-1:0]  INIT_COUNT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData
);
  tscStrobes_t      strobes;
  tscRdSel_t        rdSel;
  logic             enState;
  logic [CNT_W-1:0] cntVal;
  logic             unusedWrBits;

  // only the run bit of the write data matters
  assign unusedWrBits = ^regWrData;

  tsc_ctrl #(
    .ADDR_W (ADDR_W),
    .LO_ADDR(LO_ADDR),
    .HI_ADDR(HI_ADDR)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .regAddr (regAddr),
    .regRd   (regRd),
    .regWe   (regWe),
    .wrRunBit(regWrData[EN_BIT]),
    .strobes (strobes),
    .rdSel   (rdSel),
    .enState (enState)
  );

  tsc_datapath #(
    .CNT_W     (CNT_W),
    .DATA_W    (DATA_W),
    .EN_BIT    (EN_BIT),
    .INIT_COUNT(INIT_COUNT)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .rdSel  (rdSel),
    .enState(enState),
    .cntVal (cntVal),
    .rdData (regRdData)
  );
endmodule

// File: rtl/timestamp_counter_checker.sv
module timestamp_counter_checker #(
  parameter int CNT_W  = 40,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int EN_BIT = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 'h60,
  parameter logic [ADDR_W-1:0] HI_ADDR = 'h64
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regRd,
  input logic              regWe,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic [CNT_W-1:0]  cntVal,
  input logic              enState
);
  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (enState && tickEn) |=> cntVal == CNT_W'($past(cntVal) + 1'b1));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(enState && tickEn) |=> $stable(cntVal));

  assert_low_word_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == LO_ADDR) |-> regRdData == cntVal[DATA_W-1:0]);

  assert_high_zeros_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == HI_ADDR) |-> (regRdData[DATA_W-1:EN_BIT+1] == '0 && regRdData[EN_BIT] == enState));

  assert_run_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == HI_ADDR) |=> enState == $past(regWrData[EN_BIT]));

  assert_run_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regAddr == HI_ADDR) |=> $stable(enState));

  assert_shadow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == LO_ADDR) |=>
      (regAddr != HI_ADDR || regRdData[CNT_W-DATA_W-1:0] == $past(cntVal[CNT_W-1:DATA_W])));

  assert_rollover_R9: assert property (@(posedge clk) disable iff (!rstN)
    (enState && tickEn && cntVal == '1) |=> cntVal == '0);
endmodule

bind timestamp_counter timestamp_counter_checker #(
  .CNT_W  (CNT_W),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .EN_BIT (EN_BIT),
  .LO_ADDR(LO_ADDR),
  .HI_ADDR(HI_ADDR)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .regAddr  (regAddr),
  .regRd    (regRd),
  .regWe    (regWe),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .cntVal   (cntVal),
  .enState  (enState)
);

// File: tb/sim_timestamp_counter.sv
module sim_timestamp_counter;
  localparam logic [39:0] INIT0 = 40'h00_FFFF_FFC0;
  localparam logic [39:0] INIT1 = 40'hFF_FFFF_FFC0;
  localparam logic [7:0]  LO = 8'h60;
  localparam logic [7:0]  HI = 8'h64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic regRd = 1'b0;
  logic regWe = 1'b0;
  logic [31:0] regWrData = 32'h0;
  logic [31:0] rd0, rd1;

  int total = 0;
  int fails = 0;
  int tickMode = 0;
  int phase = 0;
  bit done = 0;

  // behavioural reference state
  logic [39:0] mCnt [2];
  logic [7:0]  mSh  [2];
  logic        mShV;
  logic        mEn;

  always #4 clk = ~clk;

  timestamp_counter #(.INIT_COUNT(INIT0)) u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regAddr(regAddr), .regRd(regRd),
    .regWe(regWe), .regWrData(regWrData), .regRdData(rd0));

  timestamp_counter #(.INIT_COUNT(INIT1)) u1 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regAddr(regAddr), .regRd(regRd),
    .regWe(regWe), .regWrData(regWrData), .regRdData(rd1));

  initial begin
    mCnt[0] = INIT0; mCnt[1] = INIT1;
    mSh[0] = 8'h0; mSh[1] = 8'h0; mShV = 1'b0; mEn = 1'b0;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt[0] = INIT0; mCnt[1] = INIT1; mShV = 1'b0; mEn = 1'b0;
      mSh[0] = 8'h0; mSh[1] = 8'h0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (regRd && regAddr == LO) mSh[i] = mCnt[i][39:32];
        if (mEn && tickEn) mCnt[i] = mCnt[i] + 40'd1;
      end
      if (regRd && regAddr == LO) mShV = 1'b1;
      else if (regRd && regAddr == HI) mShV = 1'b0;
      if (regWe && regAddr == HI) mEn = regWrData[8];
    end
  end

  function automatic logic [31:0] expRd(int i);
    if (regAddr == LO) return mCnt[i][31:0];
    if (regAddr == HI) return {23'h0, mEn, (mShV ? mSh[i] : mCnt[i][39:32])};
    return 32'h0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      string tag;
      tag = (regAddr == LO) ? "R3 model" : (regAddr == HI) ? "R4 model" : "R6 model";
      check(tag, rd0, expRd(0));
      check(tag, rd1, expRd(1));
    end
  end

  task automatic busCycle(input logic [7:0] a, input logic rd, input logic we,
                          input logic [31:0] wd, input string tag, input bit chk,
                          input logic [31:0] e0, input logic [31:0] e1);
    regAddr = a; regRd = rd; regWe = we; regWrData = wd;
    tickEn = (tickMode == 1) || (tickMode == 3 && phase == 0);
    phase = (phase + 1) % 3;
    #2;
    if (chk) begin
      check(tag, rd0, e0);
      check(tag, rd1, e1);
    end
    @(posedge clk); #1;
    regRd = 1'b0; regWe = 1'b0; regWrData = 32'h0; regAddr = 8'h00;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) busCycle(8'h00, 0, 0, 32'h0, "", 0, 0, 0);
  endtask

  task automatic rdCheck(input logic [7:0] a, input string tag, input logic [31:0] e0, input logic [31:0] e1);
    busCycle(a, 1, 0, 32'h0, tag, 1, e0, e1);
  endtask

  task automatic rdModel(input logic [7:0] a, input string tag);
    logic [31:0] e0, e1;
    regAddr = a;
    #0;
    e0 = expRd(0); e1 = expRd(1);
    busCycle(a, 1, 0, 32'h0, tag, 1, e0, e1);
  endtask

  initial begin
    #(8 * 100000);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    rdCheck(LO, "R1 low after reset", 32'hFFFF_FFC0, 32'hFFFF_FFC0);
    rdCheck(HI, "R1 high after reset", 32'h0000_0000, 32'h0000_00FF);
    // R2 ticks while stopped do nothing
    tickMode = 1;
    idle(10);
    rdCheck(LO, "R2 stopped", 32'hFFFF_FFC0, 32'hFFFF_FFC0);
    // R5 run bit clear, other bits set: stays stopped
    busCycle(HI, 0, 1, 32'hFFFF_FEFF, "", 0, 0, 0);
    rdCheck(HI, "R5 other bits ignored", 32'h0000_0000, 32'h0000_00FF);
    // R6 writes elsewhere
    busCycle(LO, 0, 1, 32'hFFFF_FFFF, "", 0, 0, 0);
    busCycle(8'h68, 0, 1, 32'hFFFF_FFFF, "", 0, 0, 0);
    rdCheck(HI, "R6 no run from other writes", 32'h0000_0000, 32'h0000_00FF);
    rdCheck(LO, "R6 count untouched", 32'hFFFF_FFC0, 32'hFFFF_FFC0);
    // start counting
    busCycle(HI, 0, 1, 32'h0000_0100, "", 0, 0, 0);
    idle(20);
    rdCheck(LO, "R2 twenty ticks", 32'hFFFF_FFD4, 32'hFFFF_FFD4);
    idle(40);
    rdCheck(LO, "R3 low before carry", 32'hFFFF_FFFD, 32'hFFFF_FFFD);
    idle(5);
    rdCheck(HI, "R7 shadowed byte", 32'h0000_0100, 32'h0000_01FF);
    rdCheck(HI, "R8 live byte", 32'h0000_0101, 32'h0000_0100);
    rdCheck(LO, "R9 after rollover", 32'h0000_0005, 32'h0000_0005);
    // sparse ticks
    tickMode = 3;
    idle(9);
    rdModel(LO, "R2 sparse ticks");
    rdModel(HI, "R4 high layout");
    rdModel(8'h10, "R4 unmapped address");
    // stop again with noise in other bits
    busCycle(HI, 0, 1, 32'hFFFF_FEFF, "", 0, 0, 0);
    idle(6);
    rdModel(LO, "R5 stopped");
    held = rd0;
    rdModel(LO, "R10 repeated read");
    rdModel(HI, "R10 high read");
    rdCheck(LO, "R10 count unchanged", held, held - 32'h0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule